// File: doc/BRIEF.md
# Two-Phase Funnel Shifter

This unit rotates a word left or right, or shifts a pair of words as one double-width funnel, in two clock cycles, using a single right shifter. A left shift is made by mirroring the bit order of the operand, shifting right and mirroring the result back. Each operation is split into two partial shifts. One shifts by the amount and the other shifts by the word width minus the amount. The first partial result is parked in an internal holding register. The second partial result is ORed with it to form the answer.

A caller pulses `start` while the unit is idle and presents the operation code and three inputs at the same edge: `word_a` (first source), `shamt` (shift amount) and `word_c` (second source, used only by funnel shifts). The FSM has three states. In `ST_IDLE` the unit waits; a start moves it to `ST_FIRST` (transition "accept"). `ST_FIRST` computes the first partial shift into the holding register and always moves on to `ST_SECOND` (transition "advance"). `ST_SECOND` combines both halves, registers the result, raises `done` for one cycle and returns to `ST_IDLE` (transition "retire"). Only one operation is in flight at a time.

For funnel shifts, bit 5 of the amount swaps the roles of the two partial shifts. A zero low amount field bypasses the shifter: it selects `word_a` directly, or `word_c` when the swap bit is set on a funnel shift.

Top module: `fsh_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first completion, `done` is 0 and `result` is 0.
- R2: Op code 00 rotates left: result = (word_a << k) | (word_a >> (32-k)), where k = shamt[4:0].
- R3: Op code 01 rotates right: result = (word_a >> k) | (word_a << (32-k)), where k = shamt[4:0].
- R4: Op code 10 (funnel left) with shamt from 1 to 31 gives (word_a << shamt) | (word_c >> (32-shamt)).
- R5: Op code 10 with shamt from 33 to 63 gives (word_a >> (32-k)) | (word_c << k), where k = shamt[4:0].
- R6: Op code 11 (funnel right) gives (word_a >> s) | (word_c << (32-s)) for s = shamt from 1 to 31. For shamt from 33 to 63 it gives (word_a << (32-k)) | (word_c >> k).
- R7: When shamt[4:0] is 0, the result is word_a. The exception is a funnel shift (op 10 or 11) with shamt = 32, which gives word_c.
- R8: A start seen at a clock edge in idle is followed by `done` high for exactly one cycle, after the second following edge, with the result valid in that cycle.
- R9: A start that arrives while an operation is in progress is ignored. Its operands do not disturb the operation in flight.
- R10: `result` keeps its last value until the next completion. The holding register is written only in the first phase.
- R11: Rotations use only shamt[4:0]. For op 00 or 01, bit 5 of shamt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled in idle only) |
| op | input | 2 | 00 rotate left, 01 rotate right, 10 funnel left, 11 funnel right |
| word_a | input | 32 | First source word |
| shamt | input | 6 | Shift amount; bit 5 is the funnel swap bit |
| word_c | input | 32 | Second source word for funnel shifts |
| result | output | 32 | Last completed result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that all inputs carry known values once reset is released. They also assume that `op`, `word_a`, `shamt` and `word_c` matter only at the edge where `start` is accepted in idle. The stimulus drives every input on the falling edge. It normally holds `start` high for a single cycle. It deliberately keeps `start` high with fresh operands through `ST_FIRST` and `ST_SECOND`, to show that those starts are dropped. It also issues a start in the cycle where `done` is high, to cover the back-to-back case. A behavioural double-word model predicts `done` and `result` on every cycle, and the design output is compared against it.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    typedef enum logic [1:0] {
        OP_ROL = 2'b00,
        OP_ROR = 2'b01,
        OP_FSL = 2'b10,
        OP_FSR = 2'b11
    } fsh_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FIRST  = 2'b01,
        ST_SECOND = 2'b10
    } fsh_state_e;

endpackage

// File: rtl/fsh_plan.sv
// Per-phase shift planning: amount, direction, source and bypass selection.
module fsh_plan
    import fsh_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  fsh_op_e         op,
    input  logic [AW:0]     amt_raw,
    input  logic            second,
    output logic [AW-1:0]   step_amt,
    output logic            step_left,
    output logic            src_third,
    output logic            bypass,
    output logic            bypass_third
);
    logic            funnel;
    logic            swap;
    logic [AW-1:0]   low;
    logic [AW:0]     compl_full;

    assign funnel     = op[1];
    assign swap       = funnel & amt_raw[AW];
    assign low        = amt_raw[AW-1:0];
    assign compl_full = (AW+1)'(WIDTH) - {1'b0, low};

    // first phase uses the amount (complement when swapped), second the other
    assign step_amt = (second ^ swap) ? compl_full[AW-1:0] : low;

    always_comb begin
        unique case (op)
            OP_ROL:  step_left = !second;
            OP_ROR:  step_left = second;
            OP_FSL:  step_left = swap ? second : !second;
            OP_FSR:  step_left = swap ? !second : second;
            default: step_left = 1'b0;
        endcase
    end

    assign src_third    = funnel & second;
    assign bypass       = (low == '0);
    assign bypass_third = swap;

endmodule

// File: rtl/fsh_partial.sv
// One logical right shifter; left shifts mirror the bit order around it.
module fsh_partial #(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src,
    input  logic [AW-1:0]    amt,
    input  logic             left,
    output logic [WIDTH-1:0] dst
);
    logic [WIDTH-1:0] mirror_in;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] mirror_out;

    for (genvar k = 0; k < WIDTH; k++) begin : g_mirror
        assign mirror_in[k]  = src[WIDTH-1-k];
        assign mirror_out[k] = shifted[WIDTH-1-k];
    end

    assign shifted = (left ? mirror_in : src) >> amt;
    assign dst     = left ? mirror_out : shifted;

endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
    import fsh_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] word_a,
    input  logic [AW:0]      shamt,
    input  logic [WIDTH-1:0] word_c,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    fsh_state_e       state_q, state_d;
    fsh_op_e          op_q;
    logic [WIDTH-1:0] a_q, c_q, hold_q, result_q;
    logic [AW:0]      amt_q;
    logic             done_q;

    logic [AW-1:0]    step_amt;
    logic             step_left, src_third, bypass, bypass_third;
    logic [WIDTH-1:0] part;

    fsh_plan #(.WIDTH(WIDTH)) u_plan (
        .op           (op_q),
        .amt_raw      (amt_q),
        .second       (state_q == ST_SECOND),
        .step_amt     (step_amt),
        .step_left    (step_left),
        .src_third    (src_third),
        .bypass       (bypass),
        .bypass_third (bypass_third)
    );

    fsh_partial #(.WIDTH(WIDTH)) u_partial (
        .src  (src_third ? c_q : a_q),
        .amt  (step_amt),
        .left (step_left),
        .dst  (part)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FIRST;
            ST_FIRST:  state_d = ST_SECOND;
            ST_SECOND: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture, datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_ROL;
            a_q      <= '0;
            c_q      <= '0;
            amt_q    <= '0;
            hold_q   <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q  <= fsh_op_e'(op);
                        a_q   <= word_a;
                        c_q   <= word_c;
                        amt_q <= shamt;
                    end
                end
                ST_FIRST: hold_q <= part;
                ST_SECOND: begin
                    result_q <= bypass ? (bypass_third ? c_q : a_q) : (hold_q | part);
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign result = result_q;
    assign done   = done_q;

    p_start_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_FIRST));
    p_second_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND) |=> done_q);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_busy_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_FIRST));
    p_operands_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(a_q) && $stable(c_q) && $stable(amt_q) && $stable(op_q)));
    p_hold_first_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FIRST) |=> $stable(hold_q));
    p_result_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_q) |-> done_q);
    p_zero_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND && amt_q[AW-1:0] == '0)
        |=> (result_q == ((op_q[1] && amt_q[AW]) ? c_q : a_q)));

endmodule

// File: tb/test_fsh_unit.sv
module test_fsh_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] word_a = '0;
    logic [5:0]  shamt = '0;
    logic [31:0] word_c = '0;
    logic [31:0] result;
    logic        done;

    int checks = 0;
    int errors = 0;
    string note = "";

    fsh_unit i_fsh_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .word_a(word_a), .shamt(shamt), .word_c(word_c),
        .result(result), .done(done)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] model_fn(logic [1:0] o, logic [31:0] a, logic [5:0] s, logic [31:0] c);
        logic [63:0] t;
        int k;
        k = int'(s[4:0]);
        case (o)
            2'b00: begin t = {a, a} << k; return t[63:32]; end
            2'b01: begin t = {a, a} >> k; return t[31:0]; end
            2'b10: begin
                if (s < 6'd32) t = {a, c} << int'(s); else t = {c, a} << k;
                return t[63:32];
            end
            default: begin
                if (s < 6'd32) t = {c, a} >> int'(s); else t = {a, c} >> k;
                return t[31:0];
            end
        endcase
    endfunction

    function automatic string tag_fn(logic [1:0] o, logic [5:0] s);
        if (s[4:0] == 5'd0) return "R7";
        case (o)
            2'b00: return (s[5] ? "R2/R11" : "R2");
            2'b01: return (s[5] ? "R3/R11" : "R3");
            2'b10: return (s[5] ? "R5" : "R4");
            default: return "R6";
        endcase
    endfunction

    // behavioural reference: stage count and expected outputs
    int          m_stage = 0;
    logic        m_done = 1'b0;
    logic [31:0] m_res = '0;
    logic [31:0] m_pend = '0;
    string       m_ptag = "";
    string       m_tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stage = 0; m_done = 1'b0; m_res = '0; m_tag = "R1";
        end else begin
            m_done = 1'b0;
            if (m_stage == 2) begin
                m_done = 1'b1; m_res = m_pend; m_tag = m_ptag; m_stage = 0;
            end else if (m_stage == 1) begin
                m_stage = 2;
            end else if (start) begin
                m_stage = 1;
                m_pend = model_fn(op, word_a, shamt, word_c);
                m_ptag = {tag_fn(op, shamt), note};
            end
            if (!m_done && m_tag != "R1") m_tag = "R10";
        end
    end

    always @(negedge clk) begin
        checks++;
        if (done !== m_done) begin
            errors++;
            $display("FAIL R8 %s: done=%0b expected %0b", m_tag, done, m_done);
        end
        checks++;
        if (result !== m_res) begin
            errors++;
            $display("FAIL %s: result=%h expected %h", m_tag, result, m_res);
        end
    end

    task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [5:0] s,
                         input logic [31:0] c, input string n);
        @(negedge clk);
        start = 1'b1; op = o; word_a = a; shamt = s; word_c = c; note = n;
        @(negedge clk);
        start = 1'b0; note = "";
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state observed by the per-cycle compare
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2, R3 rotations; R11 bit 5 ignored for rotations
        issue(2'b00, 32'h8000_0001, 6'd4, 32'hFFFF_FFFF, "");
        issue(2'b01, 32'h1234_5678, 6'd8, 32'h0, "");
        issue(2'b00, 32'hDEAD_BEEF, 6'd31, 32'h0, "");
        issue(2'b01, 32'hDEAD_BEEF, 6'd1, 32'h0, "");
        issue(2'b00, 32'hCAFE_F00D, 6'd37, 32'h5555_5555, "");
        issue(2'b01, 32'hCAFE_F00D, 6'd32, 32'h5555_5555, "");
        issue(2'b00, 32'hA5A5_0F0F, 6'd0, 32'h1111_1111, "");
        // R4, R5 funnel left
        issue(2'b10, 32'h8765_4321, 6'd1, 32'hF000_0000, "");
        issue(2'b10, 32'h8765_4321, 6'd31, 32'h0F0F_0F0F, "");
        issue(2'b10, 32'h8765_4321, 6'd33, 32'h0F0F_0F0F, "");
        issue(2'b10, 32'h8765_4321, 6'd63, 32'h0F0F_0F0F, "");
        // R6 funnel right, both ranges
        issue(2'b11, 32'h1357_9BDF, 6'd1, 32'h2468_ACE0, "");
        issue(2'b11, 32'h1357_9BDF, 6'd16, 32'h2468_ACE0, "");
        issue(2'b11, 32'h1357_9BDF, 6'd48, 32'h2468_ACE0, "");
        issue(2'b11, 32'h1357_9BDF, 6'd63, 32'h2468_ACE0, "");
        // R7 zero low field
        issue(2'b10, 32'hAAAA_0000, 6'd0, 32'h0000_BBBB, "");
        issue(2'b10, 32'hAAAA_0000, 6'd32, 32'h0000_BBBB, "");
        issue(2'b11, 32'hAAAA_0000, 6'd0, 32'h0000_BBBB, "");
        issue(2'b11, 32'hAAAA_0000, 6'd32, 32'h0000_BBBB, "");
        // R9: start held through both busy phases with other operands
        @(negedge clk);
        start = 1'b1; op = 2'b10; word_a = 32'h0123_4567; shamt = 6'd12; word_c = 32'h89AB_CDEF; note = " R9";
        @(negedge clk);
        op = 2'b01; word_a = 32'hFFFF_0000; shamt = 6'd3; note = " R9-ignored";
        @(negedge clk);
        op = 2'b11; word_a = 32'h0000_FFFF; shamt = 6'd40;
        @(negedge clk);
        start = 1'b0; note = "";
        repeat (3) @(negedge clk);
        // R8: new start during the done cycle (back to back)
        @(negedge clk);
        start = 1'b1; op = 2'b00; word_a = 32'h0F00_00F0; shamt = 6'd8; note = " R8";
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1; op = 2'b11; word_a = 32'h7777_1111; shamt = 6'd20; word_c = 32'h3333_9999;
        @(negedge clk);
        start = 1'b0; note = "";
        repeat (4) @(negedge clk);
        // mixed patterns
        for (int i = 0; i < 300; i++) begin
            issue(2'($urandom), $urandom, 6'($urandom), $urandom, "");
        end
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule